// File: doc/BRIEF.md
# Early-Late Gate Symbol Synchronizer

This block recovers symbol timing from a baseband stream that has already been filtered and demodulated and carries twenty samples per symbol. It keeps the most recent symbol's worth of samples in a sliding window. At the end of each symbol it compares the energy of the oldest sample (the early gate) with that of the newest one (the late gate). If they differ by more than a programmable deadband, the next symbol boundary moves by one sample. It then emits the sample at the window centre with a one-cycle strobe. Over a few symbols the decision instant settles on the energy peak of the symbol.

In non-coherent mode only the in-phase input drives the timing loop. In coherent mode the energies of the in-phase and quadrature branches are added. Instead of acting on every symbol, each symbol's early or late vote goes into a signed accumulator. A one-sample shift is applied only once the accumulated vote passes a threshold, and this filters out timing jitter. Samples enter with a valid qualifier, and cycles without a valid sample leave the whole block unchanged.

Top module: `elg_sync`

## Requirements
- R1: While rst_ni is low, sym_valid_o, sym_i_o and sym_q_o are zero. The sample counter, windows, period and vote accumulator are cleared, so the first strobe after reset comes after exactly 20 accepted samples.
- R2: With balanced edge energies, exactly one strobe is produced per 20 accepted samples. sym_i_o/sym_q_o carry the window centre, which is the sample accepted 9 samples before the symbol's last sample. sym_valid_o is high for a single cycle, in the cycle after the clock edge that follows the edge accepting the symbol's last sample.
- R3: Edge energy is the full-precision square of the sample, so negative and positive samples of equal magnitude behave identically.
- R4: When early energy exceeds late energy by more than deadband_i, the next symbol is 19 samples long. When late energy exceeds early energy by more than deadband_i, it is 21 samples long. Symbols after that return to 20 unless a new shift is decided.
- R5: When |early - late| is less than or equal to deadband_i, no shift is applied. A difference exactly equal to the deadband counts as balanced.
- R6: With coh_i low, smp_q_i has no effect on timing.
- R7: With coh_i high, the energy at each edge is I squared plus Q squared.
- R8: With coh_i high, each symbol adds +1 (early), -1 (late) or 0 to a vote accumulator. A sooner or later shift is applied when the sum is greater than avg_thr_i or less than -avg_thr_i, and the accumulator is then cleared. At most one sample of shift is applied per symbol, and with avg_thr_i = 0 the behaviour matches non-coherent mode.
- R9: Cycles with smp_valid_i low do not advance the counter or the windows.
- R10: A sample accepted in the same cycle as the end-of-symbol evaluation does not alter the emitted centre sample or the energy decision for that symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| coh_i | input | 1 | 1 = coherent mode: I+Q energy and vote averaging |
| deadband_i | input | 2*DW | Energy difference tolerated without shifting |
| avg_thr_i | input | TW | Vote threshold used in coherent mode |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_i_i | input | DW | In-phase sample, signed |
| smp_q_i | input | DW | Quadrature sample, signed |
| sym_valid_o | output | 1 | One-cycle strobe per symbol |
| sym_i_o | output | DW | In-phase centre sample |
| sym_q_o | output | DW | Quadrature centre sample |

## Verification
The end-of-symbol evaluation reads the registered window one cycle after the symbol's last sample is taken. With a continuous stream, the next sample is shifted into the same window on that same clock edge. The bench provokes this by holding smp_valid_i high on every cycle. It then checks that the emitted value is the centre sample of the completed symbol and not its neighbour, and that the early/late decision taken from that window produces the expected 19, 20 or 21-sample spacing between strobes. A gapped-stream test separates the two events for comparison, and the expected strobe positions shift by exactly one sample count.

// File: rtl/elg_pkg.sv
package elg_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_EARLY = 2'd1,
    STEP_LATE  = 2'd2
  } step_e;
endpackage

// File: rtl/elg_window.sv
module elg_window #(
  parameter int SPS = 20,
  parameter int DW  = 16,
  localparam int MID = SPS / 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic signed [DW-1:0] din_i,
  output logic signed [DW-1:0] early_o,
  output logic signed [DW-1:0] mid_o,
  output logic signed [DW-1:0] late_o
);
  // tap_q[0] oldest (early gate), tap_q[SPS-1] newest (late gate)
  logic signed [DW-1:0] tap_q [SPS];

  for (genvar k = 0; k < SPS; k++) begin : g_tap
    if (k == SPS - 1) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     tap_q[k] <= '0;
        else if (push_i) tap_q[k] <= din_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     tap_q[k] <= '0;
        else if (push_i) tap_q[k] <= tap_q[k+1];
      end
    end
  end

  assign early_o = tap_q[0];
  assign mid_o   = tap_q[MID];
  assign late_o  = tap_q[SPS-1];
endmodule

// File: rtl/elg_energy.sv
module elg_energy
  import elg_pkg::*;
#(
  parameter int DW = 16,
  localparam int EW  = 2 * DW,
  localparam int SW  = EW + 1,
  localparam int DFW = EW + 3
) (
  input  logic signed [DW-1:0] early_i_i,
  input  logic signed [DW-1:0] late_i_i,
  input  logic signed [DW-1:0] early_q_i,
  input  logic signed [DW-1:0] late_q_i,
  input  logic                 coh_i,
  input  logic [EW-1:0]        deadband_i,
  output step_e                step_o
);
  logic signed [EW-1:0]  ei_x, li_x, eq_x, lq_x;
  logic signed [EW-1:0]  ei_sq, li_sq, eq_sq, lq_sq;
  logic [SW-1:0]         e_early, e_late;
  logic signed [DFW-1:0] diff, db_s;

  assign ei_x = EW'(early_i_i);
  assign li_x = EW'(late_i_i);
  assign eq_x = EW'(early_q_i);
  assign lq_x = EW'(late_q_i);

  // squares are non-negative and fit EW bits
  assign ei_sq = ei_x * ei_x;
  assign li_sq = li_x * li_x;
  assign eq_sq = eq_x * eq_x;
  assign lq_sq = lq_x * lq_x;

  always_comb begin
    e_early = {1'b0, ei_sq};
    e_late  = {1'b0, li_sq};
    if (coh_i) begin
      e_early = e_early + {1'b0, eq_sq};
      e_late  = e_late  + {1'b0, lq_sq};
    end
  end

  assign diff = $signed({2'b00, e_early}) - $signed({2'b00, e_late});
  assign db_s = $signed({3'b000, deadband_i});

  always_comb begin
    if (diff > db_s)       step_o = STEP_EARLY;
    else if (-diff > db_s) step_o = STEP_LATE;
    else                   step_o = STEP_HOLD;
  end
endmodule

// File: rtl/elg_loop.sv
module elg_loop
  import elg_pkg::*;
#(
  parameter int SPS = 20,
  parameter int TW  = 6,
  localparam int PW = $clog2(SPS + 2),
  localparam int AW = TW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          coh_i,
  input  logic [TW-1:0] thr_i,
  input  step_e         step_i,
  output logic          eval_o,
  output logic [PW-1:0] period_o
);
  localparam logic [PW-1:0] P_NOM  = PW'(SPS);
  localparam logic [PW-1:0] P_SOON = PW'(SPS - 1);
  localparam logic [PW-1:0] P_LATE = PW'(SPS + 1);

  logic [PW-1:0]        cnt_q, period_q;
  logic                 eval_q;
  logic signed [AW-1:0] acc_q, acc_sum, thr_s, vote;
  logic                 fire_soon, fire_late, last_smp;

  assign last_smp = (cnt_q == period_q - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      eval_q <= 1'b0;
    end else begin
      eval_q <= push_i && last_smp;
      if (push_i) cnt_q <= last_smp ? '0 : cnt_q + PW'(1);
    end
  end

  always_comb begin
    case (step_i)
      STEP_EARLY: vote = AW'(1);
      STEP_LATE:  vote = -AW'(1);
      default:    vote = '0;
    endcase
  end

  assign acc_sum = acc_q + vote;
  assign thr_s   = $signed({2'b00, thr_i});

  always_comb begin
    if (coh_i) begin
      fire_soon = acc_sum > thr_s;
      fire_late = acc_sum < -thr_s;
    end else begin
      fire_soon = (step_i == STEP_EARLY);
      fire_late = (step_i == STEP_LATE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= P_NOM;
      acc_q    <= '0;
    end else if (eval_q) begin
      period_q <= fire_soon ? P_SOON : (fire_late ? P_LATE : P_NOM);
      acc_q    <= (!coh_i || fire_soon || fire_late) ? '0 : acc_sum;
    end
  end

  assign eval_o   = eval_q;
  assign period_o = period_q;
endmodule

// File: rtl/elg_sync.sv
module elg_sync
  import elg_pkg::*;
#(
  parameter int SPS = 20,
  parameter int DW  = 16,
  parameter int TW  = 6,
  localparam int EW = 2 * DW,
  localparam int PW = $clog2(SPS + 2),
  localparam int NB = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 coh_i,
  input  logic [EW-1:0]        deadband_i,
  input  logic [TW-1:0]        avg_thr_i,
  input  logic                 smp_valid_i,
  input  logic signed [DW-1:0] smp_i_i,
  input  logic signed [DW-1:0] smp_q_i,
  output logic                 sym_valid_o,
  output logic signed [DW-1:0] sym_i_o,
  output logic signed [DW-1:0] sym_q_o
);
  logic signed [DW-1:0] din   [NB];
  logic signed [DW-1:0] early [NB];
  logic signed [DW-1:0] mid   [NB];
  logic signed [DW-1:0] late  [NB];
  step_e                step_w;
  logic                 eval_w;
  logic [PW-1:0]        period_w;

  assign din[0] = smp_i_i;
  assign din[1] = smp_q_i;

  for (genvar b = 0; b < NB; b++) begin : g_branch
    elg_window #(.SPS(SPS), .DW(DW)) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (smp_valid_i),
      .din_i   (din[b]),
      .early_o (early[b]),
      .mid_o   (mid[b]),
      .late_o  (late[b])
    );
  end

  elg_energy #(.DW(DW)) u_energy (
    .early_i_i  (early[0]),
    .late_i_i   (late[0]),
    .early_q_i  (early[1]),
    .late_q_i   (late[1]),
    .coh_i      (coh_i),
    .deadband_i (deadband_i),
    .step_o     (step_w)
  );

  elg_loop #(.SPS(SPS), .TW(TW)) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (smp_valid_i),
    .coh_i    (coh_i),
    .thr_i    (avg_thr_i),
    .step_i   (step_w),
    .eval_o   (eval_w),
    .period_o (period_w)
  );

  // window is read one cycle after the last sample; a concurrent push lands after
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_valid_o <= 1'b0;
      sym_i_o     <= '0;
      sym_q_o     <= '0;
    end else begin
      sym_valid_o <= eval_w;
      if (eval_w) begin
        sym_i_o <= mid[0];
        sym_q_o <= mid[1];
      end
    end
  end
endmodule

// File: rtl/elg_sync_chk.sv
module elg_sync_chk #(
  parameter int SPS = 20,
  parameter int DW  = 16,
  localparam int PW = $clog2(SPS + 2)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 smp_valid_i,
  input logic                 sym_valid_o,
  input logic signed [DW-1:0] sym_i_o,
  input logic                 eval_w,
  input logic [PW-1:0]        period_w
);
  // R2
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |=> !sym_valid_o);

  // R2
  sym_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_o |-> $stable(sym_i_o));

  // R9
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sym_valid_o) |-> $past(smp_valid_i, 2));

  // R4
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_w >= PW'(SPS - 1)) && (period_w <= PW'(SPS + 1)));

  // R8
  one_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_w |=> $stable(period_w));
endmodule

bind elg_sync elg_sync_chk #(.SPS(SPS), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .sym_valid_o (sym_valid_o),
  .sym_i_o     (sym_i_o),
  .eval_w      (eval_w),
  .period_w    (period_w)
);

// File: tb/sim_elg_sync.sv
module sim_elg_sync;
  localparam int DW = 16;
  localparam int TW = 6;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 coh = 1'b0;
  logic [2*DW-1:0]      deadband = '0;
  logic [TW-1:0]        thr = '0;
  logic                 smp_valid = 1'b0;
  logic signed [DW-1:0] smp_i = '0, smp_q = '0;
  logic                 sym_valid;
  logic signed [DW-1:0] sym_i, sym_q;

  int n_tests = 0, n_fail = 0, n_cap = 0, st_cnt = 0;
  int st_n [16];
  int st_i [16];
  int st_q [16];
  bit done = 0;

  always #10 clk = ~clk;

  elg_sync u0 (
    .clk_i(clk), .rst_ni(rst_ni), .coh_i(coh), .deadband_i(deadband),
    .avg_thr_i(thr), .smp_valid_i(smp_valid), .smp_i_i(smp_i), .smp_q_i(smp_q),
    .sym_valid_o(sym_valid), .sym_i_o(sym_i), .sym_q_o(sym_q)
  );

  always @(posedge clk) if (rst_ni && smp_valid) n_cap++;

  always @(negedge clk) begin
    if (sym_valid && st_cnt < 16) begin
      st_n[st_cnt] = n_cap;
      st_i[st_cnt] = int'(sym_i);
      st_q[st_cnt] = int'(sym_q);
      st_cnt++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // symmetric pulse over one symbol, balanced when aligned
  function automatic int tri_v(int k);
    int m = k % 20;
    return 10 * ((m < 19 - m) ? m : 19 - m);
  endfunction

  function automatic int pick(int mode, int k);
    case (mode)
      1: return tri_v(k);
      2: return -tri_v(k);
      3: return (k % 20) * 100;
      default: return 0;
    endcase
  endfunction

  task automatic do_reset(bit c, int db, int t);
    @(negedge clk);
    rst_ni = 1'b0; smp_valid = 1'b0;
    coh = c; deadband = (2*DW)'(db); thr = TW'(t);
    repeat (2) @(negedge clk);
    chk(sym_valid == 1'b0, "R1 valid", int'(sym_valid), 0);
    chk(sym_i == 0, "R1 sym_i", int'(sym_i), 0);
    chk(sym_q == 0, "R1 sym_q", int'(sym_q), 0);
    n_cap = 0; st_cnt = 0;
    rst_ni = 1'b1;
  endtask

  task automatic feed(int cnt, int offi, int mi, int offq, int mq, bit gap);
    for (int n = 0; n < cnt; n++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_i = DW'(pick(mi, n + offi));
      smp_q = DW'(pick(mq, n + offq));
      if (gap) begin
        @(negedge clk);
        smp_valid = 1'b0;
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_st(string req, int k, int en [5], int ev [5], bit use_q);
    chk(st_cnt >= k, {req, " strobe count"}, st_cnt, k);
    for (int j = 0; j < k; j++) begin
      chk(st_n[j] == en[j], {req, " strobe position"}, st_n[j], en[j]);
      chk((use_q ? st_q[j] : st_i[j]) == ev[j], {req, " centre value"},
          use_q ? st_q[j] : st_i[j], ev[j]);
    end
  endtask

  task automatic t_quad_ignored; // R2 R6 R10
    do_reset(0, 0, 0);
    feed(70, 0, 1, 0, 3, 0);
    expect_st("R2_R6", 3, '{21, 41, 61, 0, 0}, '{90, 90, 90, 0, 0}, 0);
  endtask

  task automatic t_early; // R4 R10
    do_reset(0, 0, 0);
    feed(100, 3, 1, 0, 0, 0);
    expect_st("R4_early", 5, '{21, 40, 59, 78, 98}, '{60, 70, 80, 90, 90}, 0);
  endtask

  task automatic t_late; // R4
    do_reset(0, 0, 0);
    feed(90, 17, 1, 0, 0, 0);
    expect_st("R4_late", 4, '{21, 42, 63, 84, 0}, '{70, 80, 90, 90, 0}, 0);
  endtask

  task automatic t_deadband; // R5
    do_reset(0, 500, 0);
    feed(70, 3, 1, 0, 0, 0);
    expect_st("R5_equal", 3, '{21, 41, 61, 0, 0}, '{60, 60, 60, 0, 0}, 0);
    do_reset(0, 499, 0);
    feed(50, 3, 1, 0, 0, 0);
    expect_st("R5_above", 2, '{21, 40, 0, 0, 0}, '{60, 70, 0, 0, 0}, 0);
  endtask

  task automatic t_coh_q; // R7
    do_reset(1, 0, 0);
    feed(100, 0, 0, 3, 1, 0);
    expect_st("R7_q", 5, '{21, 40, 59, 78, 98}, '{60, 70, 80, 90, 90}, 1);
    expect_st("R7_i", 2, '{21, 40, 0, 0, 0}, '{0, 0, 0, 0, 0}, 0);
  endtask

  task automatic t_avg; // R8
    do_reset(1, 0, 2);
    feed(90, 3, 1, 0, 0, 0);
    expect_st("R8", 4, '{21, 41, 61, 80, 0}, '{60, 60, 60, 70, 0}, 0);
  endtask

  task automatic t_gap_neg; // R3 R9
    do_reset(0, 0, 0);
    feed(60, 0, 2, 0, 0, 1);
    expect_st("R3_R9", 3, '{20, 40, 60, 0, 0}, '{-90, -90, -90, 0, 0}, 0);
  endtask

  task automatic t_mid_reset; // R1
    do_reset(0, 0, 0);
    feed(30, 5, 1, 0, 0, 0);
    do_reset(0, 0, 0);
    feed(45, 0, 1, 0, 0, 0);
    expect_st("R1_restart", 2, '{21, 41, 0, 0, 0}, '{90, 90, 0, 0, 0}, 0);
  endtask

  initial begin
    t_quad_ignored();
    t_early();
    t_late();
    t_deadband();
    t_coh_q();
    t_avg();
    t_gap_neg();
    t_mid_reset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule